// File: doc/BRIEF.md
# Whole-Line Write Coverage Tracker

This block lives inside one outstanding-miss entry of a cache. Each request merged into the entry is shown to it once. The request carries a write/read indication, a byte offset, a byte count and a set of attribute bits. The block decides whether every merged request so far is a plain write, and whether those writes together cover every byte of the line. If both hold, the memory fetch for the line can be skipped and the writes can simply fill it.

A small state machine tracks eligibility and has four states:

- `ST_EMPTY`: still eligible, and no byte is covered yet.
- `ST_GATHER`: still eligible, and some bytes are covered.
- `ST_FULL`: every byte is covered.
- `ST_MIXED`: eligibility is lost until the next init.

The named transitions are:

- `T_INIT`: any state goes to `ST_EMPTY` on init or reset.
- `T_COVER`: `ST_EMPTY` or `ST_GATHER` goes to `ST_GATHER` when a mergeable write leaves some byte uncovered.
- `T_COMPLETE`: `ST_EMPTY` or `ST_GATHER` goes to `ST_FULL` when a mergeable write completes the coverage.
- `T_SPOIL`: `ST_EMPTY` or `ST_GATHER` goes to `ST_MIXED` on any read or on a write with an attribute bit set.
- `T_HOLD`: `ST_FULL` and `ST_MIXED` stay where they are.

A mergeable write of zero bytes leaves `ST_EMPTY` unchanged. A per-byte coverage bitmap is kept beside the state. A send strobe copies the current whole-line indication into a held flag, which the fill logic uses later.

Top module: `wlw_tracker`

## Requirements
- R1: After asynchronous reset or a synchronous `init_i` pulse, the outputs are as follows. `reset_state_o`=1, `whole_line_o`=0 and `was_whole_line_o`=0, all visible after the clock edge that samples the init.
- R2: A request is mergeable only if it is a write and all eight attribute bits are zero. The attribute bits are: bit0 uncacheable, bit1 strictly ordered, bit2 memory-mapped register, bit3 privileged, bit4 load-linked/store-conditional, bit5 swap, bit6 conditional swap, bit7 secure.
- R3: A single non-mergeable request seen before the line is covered removes eligibility until the next init. After it, `whole_line_o` stays 0 and `reset_state_o` is 0, even if later writes cover the whole line.
- R4: While eligible, a mergeable write marks bytes offset through offset+size-1 as covered. Coverage accumulates across requests.
- R5: Byte ranges that run past byte 63 of the 64-byte line are clipped at byte 63.
- R6: `whole_line_o` is 1 exactly when the entry is eligible and all 64 bytes are covered. It rises in the cycle after the completing request.
- R7: Once `whole_line_o` is 1, later requests change nothing. This includes reads and writes with attribute bits, and it holds until init.
- R8: On `send_i`, `was_whole_line_o` takes the value `whole_line_o` had before that edge, so a request in the same cycle is not included. The flag then holds until the next send or init, whatever requests arrive.
- R9: `reset_state_o` is 1 exactly when the entry is eligible and no byte is covered. A mergeable write of size 0 leaves it at 1.
- R10: An init in the same cycle as a request or a send wins. The result is the reset condition of R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_i | input | 1 | Synchronous re-initialise for a newly allocated entry |
| req_valid_i | input | 1 | A request is merged this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_offset_i | input | 6 | First byte within the line |
| req_size_i | input | 7 | Byte count, 0 to 64 |
| req_attr_i | input | 8 | Attribute bits; any set bit blocks merging |
| send_i | input | 1 | Miss is sent now; latch the whole-line state |
| whole_line_o | output | 1 | All merged requests are plain writes covering the line |
| was_whole_line_o | output | 1 | Whole-line value captured at the last send |
| reset_state_o | output | 1 | Eligible with nothing covered yet |

## Verification
The hardest case to reach is a line that is fully covered only after clipping. In that case a range overruns byte 63 and a second, smaller write fills the low half. The stimulus table gets there from `ST_EMPTY` through a zero-size write and an overrunning write, then completes the line. The table also drives the two same-cycle collisions: send with a completing write, and init with a full write and send. A directed loop then spoils an otherwise complete write with each attribute bit in turn.

// File: rtl/wlw_pkg.sv
package wlw_pkg;
    localparam int LINE_BYTES = 64;
    localparam int NUM_ATTR   = 8;

    typedef enum logic [1:0] {
        ST_EMPTY  = 2'd0,
        ST_GATHER = 2'd1,
        ST_FULL   = 2'd2,
        ST_MIXED  = 2'd3
    } wlw_state_e;
endpackage

// File: rtl/wlw_merge_check.sv
module wlw_merge_check #(
    parameter int NUM_ATTR = 8
) (
    input  logic                valid_i,
    input  logic                write_i,
    input  logic [NUM_ATTR-1:0] attr_i,
    output logic                mergeable_o,
    output logic                spoil_o
);
    // A request may join the coverage only as a write free of every attribute bit.
    always_comb begin
        mergeable_o = valid_i && write_i && (attr_i == '0);
        spoil_o     = valid_i && !mergeable_o;
    end
endmodule

// File: rtl/wlw_span_mask.sv
module wlw_span_mask #(
    parameter int LINE_BYTES = 64
) (
    input  logic [$clog2(LINE_BYTES)-1:0] offset_i,
    input  logic [$clog2(LINE_BYTES):0]   size_i,
    output logic [LINE_BYTES-1:0]         mask_o
);
    localparam int OFS_W = $clog2(LINE_BYTES);
    localparam int END_W = OFS_W + 2;

    logic [END_W-1:0] first;
    logic [END_W-1:0] limit;

    always_comb begin
        first = {2'b00, offset_i};
        limit = first + {1'b0, size_i};
    end

    // Bytes at or beyond the line end simply have no bit, which clips the range.
    for (genvar i = 0; i < LINE_BYTES; i++) begin : g_byte
        localparam logic [END_W-1:0] IDX = END_W'(i);
        assign mask_o[i] = (IDX >= first) && (IDX < limit);
    end
endmodule

// File: rtl/wlw_tracker.sv
module wlw_tracker
    import wlw_pkg::*;
#(
    parameter int LINE_BYTES = wlw_pkg::LINE_BYTES,
    parameter int NUM_ATTR   = wlw_pkg::NUM_ATTR,
    localparam int OFS_W     = $clog2(LINE_BYTES),
    localparam int SIZE_W    = OFS_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_i,
    input  logic              req_valid_i,
    input  logic              req_write_i,
    input  logic [OFS_W-1:0]  req_offset_i,
    input  logic [SIZE_W-1:0] req_size_i,
    input  logic [NUM_ATTR-1:0] req_attr_i,
    input  logic              send_i,
    output logic              whole_line_o,
    output logic              was_whole_line_o,
    output logic              reset_state_o
);
    wlw_state_e            state_q, state_d;
    logic [LINE_BYTES-1:0] cover_q, cover_d;
    logic [LINE_BYTES-1:0] span;
    logic                  mergeable, spoil;
    logic                  was_q;

    wlw_merge_check #(.NUM_ATTR(NUM_ATTR)) u_merge (
        .valid_i     (req_valid_i),
        .write_i     (req_write_i),
        .attr_i      (req_attr_i),
        .mergeable_o (mergeable),
        .spoil_o     (spoil)
    );

    wlw_span_mask #(.LINE_BYTES(LINE_BYTES)) u_span (
        .offset_i (req_offset_i),
        .size_i   (req_size_i),
        .mask_o   (span)
    );

    // Next state and next coverage
    always_comb begin
        state_d = state_q;
        cover_d = cover_q;
        if (init_i) begin
            state_d = ST_EMPTY;                      // T_INIT
            cover_d = '0;
        end else begin
            unique case (state_q)
                ST_EMPTY, ST_GATHER: begin
                    if (spoil) begin
                        state_d = ST_MIXED;          // T_SPOIL
                    end else if (mergeable) begin
                        cover_d = cover_q | span;
                        if (&cover_d)
                            state_d = ST_FULL;       // T_COMPLETE
                        else if (cover_d != '0)
                            state_d = ST_GATHER;     // T_COVER
                    end
                end
                ST_FULL, ST_MIXED: state_d = state_q; // T_HOLD
                default: state_d = ST_EMPTY;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
            cover_q <= '0;
            was_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cover_q <= cover_d;
            if (init_i)
                was_q <= 1'b0;
            else if (send_i)
                was_q <= (state_q == ST_FULL);
        end
    end

    // Outputs
    always_comb begin
        whole_line_o     = (state_q == ST_FULL);
        reset_state_o    = (state_q == ST_EMPTY);
        was_whole_line_o = was_q;
    end
endmodule

// File: rtl/wlw_tracker_checker.sv
module wlw_tracker_checker #(
    parameter int NUM_ATTR = 8,
    parameter int OFS_W    = 6,
    parameter int SIZE_W   = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              init_i,
    input logic              req_valid_i,
    input logic              req_write_i,
    input logic [OFS_W-1:0]  req_offset_i,
    input logic [SIZE_W-1:0] req_size_i,
    input logic [NUM_ATTR-1:0] req_attr_i,
    input logic              send_i,
    input logic              whole_line_o,
    input logic              was_whole_line_o,
    input logic              reset_state_o
);
    a_r1_init_clears: assert property (@(posedge clk) disable iff (!rst_n)
        init_i |=> (reset_state_o && !whole_line_o && !was_whole_line_o));

    a_r3_spoil_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && (!req_write_i || req_attr_i != '0) && !whole_line_o && !init_i)
        |=> (!whole_line_o && !reset_state_o));

    a_r6_full_write: assert property (@(posedge clk) disable iff (!rst_n)
        (reset_state_o && req_valid_i && req_write_i && req_attr_i == '0 &&
         req_offset_i == '0 && req_size_i >= SIZE_W'(1 << OFS_W) && !init_i)
        |=> whole_line_o);

    a_r7_full_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (whole_line_o && !init_i) |=> whole_line_o);

    a_r8_was_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (send_i && !init_i) |=> (was_whole_line_o == $past(whole_line_o)));

    a_r8_was_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!send_i && !init_i) |=> $stable(was_whole_line_o));

    a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(whole_line_o && reset_state_o));
endmodule

bind wlw_tracker wlw_tracker_checker #(
    .NUM_ATTR (NUM_ATTR),
    .OFS_W    (OFS_W),
    .SIZE_W   (SIZE_W)
) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .init_i           (init_i),
    .req_valid_i      (req_valid_i),
    .req_write_i      (req_write_i),
    .req_offset_i     (req_offset_i),
    .req_size_i       (req_size_i),
    .req_attr_i       (req_attr_i),
    .send_i           (send_i),
    .whole_line_o     (whole_line_o),
    .was_whole_line_o (was_whole_line_o),
    .reset_state_o    (reset_state_o)
);

// File: tb/wlw_tracker_tb.sv
module wlw_tracker_tb;
    typedef struct packed {
        logic       init;
        logic       valid;
        logic       wr;
        logic [5:0] off;
        logic [6:0] sz;
        logic [7:0] attr;
        logic       send;
        logic       ew;
        logic       er;
        logic       ewas;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VECS [NV] = '{
        '{1,0,0, 6'd0, 7'd0,  8'h00,0, 0,1,0}, // 0  R1 init
        '{0,1,1, 6'd0, 7'd32, 8'h00,0, 0,0,0}, // 1  R4 low half
        '{0,0,0, 6'd0, 7'd0,  8'h00,1, 0,0,0}, // 2  R8 send while partial
        '{0,1,1, 6'd32,7'd32, 8'h00,0, 1,0,0}, // 3  R4 R6 high half completes
        '{0,1,0, 6'd0, 7'd8,  8'h00,0, 1,0,0}, // 4  R7 read ignored
        '{0,1,1, 6'd0, 7'd4,  8'h01,0, 1,0,0}, // 5  R7 uncacheable ignored
        '{0,0,0, 6'd0, 7'd0,  8'h00,1, 1,0,1}, // 6  R8 send while full
        '{1,0,0, 6'd0, 7'd0,  8'h00,0, 0,1,0}, // 7  R1 re-init
        '{0,1,1, 6'd16,7'd16, 8'h00,0, 0,0,0}, // 8  R4
        '{0,1,1, 6'd0, 7'd64, 8'h80,0, 0,0,0}, // 9  R2 R3 secure write spoils
        '{0,1,1, 6'd0, 7'd64, 8'h00,0, 0,0,0}, // 10 R3 stays ineligible
        '{1,0,0, 6'd0, 7'd0,  8'h00,0, 0,1,0}, // 11 R1
        '{0,1,1, 6'd10,7'd0,  8'h00,0, 0,1,0}, // 12 R9 zero size
        '{0,1,1, 6'd32,7'd64, 8'h00,0, 0,0,0}, // 13 R5 clipped
        '{0,1,1, 6'd0, 7'd32, 8'h00,0, 1,0,0}, // 14 R5 R6 completes
        '{0,1,0, 6'd0, 7'd8,  8'h00,1, 1,0,1}, // 15 R7 R8 read with send
        '{1,1,1, 6'd0, 7'd64, 8'h00,1, 0,1,0}, // 16 R10 init wins
        '{0,1,0, 6'd0, 7'd64, 8'h00,0, 0,0,0}, // 17 R3 read spoils
        '{1,0,0, 6'd0, 7'd0,  8'h00,0, 0,1,0}, // 18 R1
        '{0,1,1, 6'd0, 7'd64, 8'h10,0, 0,0,0}, // 19 R2 ll/sc spoils
        '{1,0,0, 6'd0, 7'd0,  8'h00,0, 0,1,0}, // 20 R1
        '{0,1,1, 6'd0, 7'd63, 8'h00,0, 0,0,0}, // 21 R6 one byte short
        '{0,1,1, 6'd63,7'd1,  8'h00,0, 1,0,0}, // 22 R6 last byte
        '{1,0,0, 6'd0, 7'd0,  8'h00,0, 0,1,0}, // 23 R1
        '{0,1,1, 6'd0, 7'd64, 8'h00,1, 1,0,0}, // 24 R8 send sees pre-request
        '{0,1,0, 6'd0, 7'd8,  8'h00,0, 1,0,0}  // 25 R8 held
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       init_i = 1'b0;
    logic       req_valid_i = 1'b0;
    logic       req_write_i = 1'b0;
    logic [5:0] req_offset_i = '0;
    logic [6:0] req_size_i = '0;
    logic [7:0] req_attr_i = '0;
    logic       send_i = 1'b0;
    logic       whole_line_o, was_whole_line_o, reset_state_o;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    wlw_tracker u_dut (
        .clk              (clk),
        .rst_n            (rst_n),
        .init_i           (init_i),
        .req_valid_i      (req_valid_i),
        .req_write_i      (req_write_i),
        .req_offset_i     (req_offset_i),
        .req_size_i       (req_size_i),
        .req_attr_i       (req_attr_i),
        .send_i           (send_i),
        .whole_line_o     (whole_line_o),
        .was_whole_line_o (was_whole_line_o),
        .reset_state_o    (reset_state_o)
    );

    task automatic check(input string tag, input logic ew, input logic er, input logic ewas);
        n_checks++;
        if (whole_line_o !== ew || reset_state_o !== er || was_whole_line_o !== ewas) begin
            n_fail++;
            $display("FAIL %s: got whole=%0b reset=%0b was=%0b expected whole=%0b reset=%0b was=%0b",
                     tag, whole_line_o, reset_state_o, was_whole_line_o, ew, er, ewas);
        end
    endtask

    task automatic drive(input vec_t v);
        init_i = v.init; req_valid_i = v.valid; req_write_i = v.wr;
        req_offset_i = v.off; req_size_i = v.sz; req_attr_i = v.attr; send_i = v.send;
        @(negedge clk);
    endtask

    localparam vec_t IDLE    = '{0,0,0,6'd0,7'd0,8'h00,0,0,0,0};
    localparam vec_t DO_INIT = '{1,0,0,6'd0,7'd0,8'h00,0,0,0,0};

    initial begin
        repeat (2) @(negedge clk);
        check("R1 reset", 1'b0, 1'b1, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i]);
            check($sformatf("vector %0d (see R-tag in table)", i), VECS[i].ew, VECS[i].er, VECS[i].ewas);
        end

        // R2: each attribute bit alone spoils a complete write
        for (int b = 0; b < 8; b++) begin
            vec_t v;
            drive(DO_INIT);
            v = '{0,1,1,6'd0,7'd64,8'h00,0,0,0,0};
            v.attr = 8'(1 << b);
            drive(v);
            check($sformatf("R2 attr bit %0d", b), 1'b0, 1'b0, 1'b0);
        end

        // R1: asynchronous reset from the full state
        drive(DO_INIT);
        drive('{0,1,1,6'd0,7'd64,8'h00,1,0,0,0});
        drive('{0,0,0,6'd0,7'd0,8'h00,1,0,0,0});
        check("R1 pre-reset full", 1'b1, 1'b0, 1'b1);
        drive(IDLE);
        #3 rst_n = 1'b0;
        #3 check("R1 async reset", 1'b0, 1'b1, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset release", 1'b0, 1'b1, 1'b0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end
endmodule